// File: doc/BRIEF.md
# Resolver Register Access Sequencer

This block sits on the host side of a serial link to a resolver-to-digital converter and carries out single register reads and writes on it. A requester hands over one access at a time: a direction bit, an 8-bit register address and, for writes, a data byte. The sequencer first drives both converter mode pins high, which selects configuration mode. It then runs two separate one-byte SPI mode 0 frames, with chip select released between them. The first frame carries the address. The second frame carries either the write data or, for a read, a dummy byte that is the control register address. The byte that comes back in the second frame is the read result.

Converter registers hold only 7 data bits, so a write whose data has bit 7 set is refused. The refusal is an error response and no pin moves. On a read, bit 7 of the returned byte flags a configuration parity error when the register lies above the velocity low-byte address. The fault register is the exception, because there bit 7 is a fault flag. A write to the soft-reset register, or a read of the fault register, gives a one-cycle strobe that tells the surrounding logic to forget its fault history.

Top module: `resolver_reg_seq`

## Requirements
- R1: A write request whose data byte has bit 7 set is answered in the cycle after acceptance with rsp_valid_o=1, rsp_err_o=1 and rsp_data_o=0. cs_no stays high, sclk_o stays low and mode_o keeps its value.
- R2: An accepted valid access produces exactly two chip-select frames, each with exactly eight sclk_o rising edges. cs_no stays high for exactly SPI_DIV system cycles between the two frames.
- R3: The first frame shifts out the request address MSB first. For a write, the second frame shifts out the 8-bit data byte MSB first.
- R4: For a read, the second frame shifts out the control register address (default 8'h92). rsp_data_o returns the eight bits received on miso_i during that frame, with the first bit received as bit 7.
- R5: mode_o resets to 2'b00. It becomes 2'b11 in the cycle after a valid access is accepted and stays 2'b11. cs_no falls SPI_DIV/2 cycles after mode_o becomes 2'b11.
- R6: A read response has rsp_err_o=1 exactly when the address is above the velocity low-byte address (default 8'h83), is not the fault register address (default 8'hFF), and bit 7 of the returned byte is 1. Successful writes answer with rsp_err_o=0 and rsp_data_o=0.
- R7: fault_clr_o is high for exactly the response cycle of a write to the soft-reset address (default 8'hF0) or a read of the fault register address, and low at all other times. This includes refused writes.
- R8: SPI mode 0 timing holds. sclk_o is low whenever cs_no is high. Each sclk_o high and low phase lasts SPI_DIV/2 system cycles. mosi_o changes within a frame only together with a falling sclk_o, and it is 0 outside frames. miso_i is captured when sclk_o rises.
- R9: req_ready_o is low from the cycle after a valid access is accepted until the cycle in which cs_no returns high after the second frame. In that same cycle rsp_valid_o is high for one cycle.
- R10: During reset cs_no=1, sclk_o=0, mosi_o=0, req_ready_o=1, rsp_valid_o=0, fault_clr_o=0 and mode_o=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Sequencer can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Register address |
| req_data_i | input | 8 | Write data; bit 7 must be 0 |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | 8 | Read result, 0 for writes |
| rsp_err_o | output | 1 | Refused write or parity error |
| fault_clr_o | output | 1 | Clear fault history strobe |
| mode_o | output | 2 | Converter mode pins |
| cs_no | output | 1 | SPI chip select, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to converter |
| miso_i | input | 1 | SPI data from converter |

## Verification
With H = SPI_DIV/2 and acceptance taken as cycle 0, cs_no falls in cycle H+1. The first frame occupies 17·H cycles and the gap SPI_DIV cycles. The response is therefore due in cycle 2·17·H + H + SPI_DIV + 1, which is cycle 75 with the defaults, and a refused write answers in cycle 1. For each request the bench builds the whole expected waveform of every output, one queue entry per cycle, from these counts. It compares the waveform at every falling clock edge, so any output that arrives a cycle early or late shows up as a mismatch. A converter model on the bench side shifts a chosen byte out on miso_i, so that read data and parity decoding are checked against known values.

// File: rtl/resolver_seq_pkg.sv
package resolver_seq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FRAME1,
    ST_GAP,
    ST_FRAME2
  } seq_state_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import resolver_seq_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o
);
  localparam int HCW       = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int LAST_HALF = 2 * BYTE_W;
  localparam int IDXW      = $clog2(LAST_HALF + 1);

  logic              active;
  logic [HCW-1:0]    hcnt;
  logic [IDXW-1:0]   hidx;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] rxreg;
  logic              half_end;

  assign half_end  = active && (hcnt == HCW'(HALF - 1));
  assign done_o    = half_end && (hidx == IDXW'(LAST_HALF));
  assign busy_o    = active;
  assign rx_byte_o = rxreg;
  assign mosi_o    = shreg[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      hcnt   <= '0;
      hidx   <= '0;
      shreg  <= '0;
      rxreg  <= '0;
      sclk_o <= 1'b0;
      cs_no  <= 1'b1;
    end else if (start_i && !active) begin
      active <= 1'b1;
      cs_no  <= 1'b0;
      sclk_o <= 1'b0;
      shreg  <= tx_byte_i;
      hcnt   <= '0;
      hidx   <= '0;
    end else if (half_end) begin
      hcnt <= '0;
      if (done_o) begin
        active <= 1'b0;
        cs_no  <= 1'b1;
      end else begin
        hidx <= hidx + 1'b1;
        if (!hidx[0]) begin
          // entering high phase: capture
          sclk_o <= 1'b1;
          rxreg  <= {rxreg[BYTE_W-2:0], miso_i};
        end else begin
          // entering low phase: advance output bit
          sclk_o <= 1'b0;
          shreg  <= {shreg[BYTE_W-2:0], 1'b0};
        end
      end
    end else if (active) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assert_sclk_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  assert_mosi_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no) && (mosi_o != $past(mosi_o))) |-> $fell(sclk_o));

  assert_no_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && active) |=> !cs_no);
endmodule

// File: rtl/resp_decode.sv
module resp_decode
  import resolver_seq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR_VEL_LSB = 8'h83,
  parameter logic [BYTE_W-1:0] ADDR_FAULT   = 8'hFF,
  parameter logic [BYTE_W-1:0] ADDR_SRST    = 8'hF0
) (
  input  logic              is_write_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic              parity_err_o,
  output logic              clr_hist_o
);
  logic checked_reg;

  // bit 7 means a fault flag on the fault register, parity elsewhere above velocity
  assign checked_reg  = (addr_i > ADDR_VEL_LSB) && (addr_i != ADDR_FAULT);
  assign parity_err_o = !is_write_i && checked_reg && rx_i[BYTE_W-1];
  assign clr_hist_o   = (is_write_i && (addr_i == ADDR_SRST)) ||
                        (!is_write_i && (addr_i == ADDR_FAULT));
endmodule

// File: rtl/resolver_reg_seq.sv
module resolver_reg_seq
  import resolver_seq_pkg::*;
#(
  parameter int                SPI_DIV      = 4,
  parameter logic [BYTE_W-1:0] ADDR_CTRL    = 8'h92,
  parameter logic [BYTE_W-1:0] ADDR_VEL_LSB = 8'h83,
  parameter logic [BYTE_W-1:0] ADDR_FAULT   = 8'hFF,
  parameter logic [BYTE_W-1:0] ADDR_SRST    = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BYTE_W-1:0] req_addr_i,
  input  logic [BYTE_W-1:0] req_data_i,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_data_o,
  output logic              rsp_err_o,
  output logic              fault_clr_o,
  output logic [1:0]        mode_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int HALF      = SPI_DIV / 2;
  localparam int SETUP_CYC = HALF;
  localparam int GAP_CYC   = SPI_DIV;
  localparam int WCW       = $clog2(GAP_CYC + 1);

  seq_state_e        state;
  logic [WCW-1:0]    wcnt;
  logic              lat_write;
  logic [BYTE_W-1:0] lat_addr;
  logic [BYTE_W-1:0] lat_data;
  logic              wait_done;
  logic              eng_start;
  logic [BYTE_W-1:0] eng_byte;
  logic              eng_busy;
  logic              eng_done;
  logic [BYTE_W-1:0] eng_rx;
  logic              dec_err;
  logic              dec_clr;
  logic              bad_write;

  assign bad_write   = req_write_i && req_data_i[BYTE_W-1];
  assign req_ready_o = (state == ST_IDLE);

  always_comb begin
    wait_done = 1'b0;
    if (state == ST_SETUP) wait_done = (wcnt == WCW'(SETUP_CYC - 1));
    if (state == ST_GAP)   wait_done = (wcnt == WCW'(GAP_CYC - 1));
  end

  assign eng_start = wait_done;
  assign eng_byte  = (state == ST_SETUP) ? lat_addr :
                     (lat_write ? lat_data : ADDR_CTRL);

  spi_byte_shifter #(
    .HALF (HALF)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .tx_byte_i (eng_byte),
    .miso_i    (miso_i),
    .busy_o    (eng_busy),
    .done_o    (eng_done),
    .rx_byte_o (eng_rx),
    .sclk_o    (sclk_o),
    .cs_no     (cs_no),
    .mosi_o    (mosi_o)
  );

  resp_decode #(
    .ADDR_VEL_LSB (ADDR_VEL_LSB),
    .ADDR_FAULT   (ADDR_FAULT),
    .ADDR_SRST    (ADDR_SRST)
  ) u_decode (
    .is_write_i   (lat_write),
    .addr_i       (lat_addr),
    .rx_i         (eng_rx),
    .parity_err_o (dec_err),
    .clr_hist_o   (dec_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      wcnt        <= '0;
      lat_write   <= 1'b0;
      lat_addr    <= '0;
      lat_data    <= '0;
      mode_o      <= 2'b00;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_err_o   <= 1'b0;
      fault_clr_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      fault_clr_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (bad_write) begin
              rsp_valid_o <= 1'b1;
              rsp_err_o   <= 1'b1;
              rsp_data_o  <= '0;
            end else begin
              lat_write <= req_write_i;
              lat_addr  <= req_addr_i;
              lat_data  <= req_data_i;
              mode_o    <= 2'b11;
              wcnt      <= '0;
              state     <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (wait_done) state <= ST_FRAME1;
          else           wcnt  <= wcnt + 1'b1;
        end
        ST_FRAME1: begin
          if (eng_done) begin
            wcnt  <= '0;
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (wait_done) state <= ST_FRAME2;
          else           wcnt  <= wcnt + 1'b1;
        end
        ST_FRAME2: begin
          if (eng_done) begin
            state       <= ST_IDLE;
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= dec_err;
            rsp_data_o  <= lat_write ? '0 : eng_rx;
            fault_clr_o <= dec_clr;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && bad_write) |=> (rsp_valid_o && rsp_err_o && cs_no));

  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start |-> !eng_busy);

  assert_mode_cfg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> (mode_o == 2'b11));

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);

  assert_clr_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_clr_o |=> !fault_clr_o);

  assert_clr_with_rsp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_clr_o |-> (rsp_valid_o && !rsp_err_o));
endmodule

// File: tb/tb_resolver_reg_seq.sv
module tb_resolver_reg_seq;
  localparam int SPI_DIV = 4;
  localparam int HALF    = SPI_DIV / 2;
  localparam int FRAME   = 17 * HALF;

  typedef struct {
    bit       cs_n;
    bit       sclk;
    bit       mosi;
    bit       rdy;
    bit       rv;
    bit       re;
    bit       fc;
    bit [1:0] mode;
    bit [7:0] rd;
  } exp_t;

  logic       clk, rst_n;
  logic       req_valid, req_ready, req_write;
  logic [7:0] req_addr, req_data;
  logic       rsp_valid, rsp_err, fault_clr;
  logic [7:0] rsp_data;
  logic [1:0] mode;
  logic       cs_n, sclk, mosi, miso;

  int       checks = 0;
  int       failures = 0;
  bit       finished = 0;
  bit [1:0] mode_exp = 2'b00;
  exp_t     q[$];

  bit [7:0] sl_byte = 8'h00;
  int       sl_bit = 0;

  resolver_reg_seq #(.SPI_DIV(SPI_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_err_o(rsp_err),
    .fault_clr_o(fault_clr), .mode_o(mode),
    .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // converter model: shifts sl_byte out MSB first, mode 0
  initial miso = 1'b0;
  always @(negedge cs_n) begin
    sl_bit = 0;
    miso = sl_byte[7];
  end
  always @(negedge sclk) if (!cs_n) begin
    sl_bit++;
    if (sl_bit < 8) miso = sl_byte[7-sl_bit];
  end

  task automatic chk(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, name, act, exp, $time);
    end
  endtask

  function automatic exp_t idle_entry();
    exp_t e;
    e.cs_n = 1; e.sclk = 0; e.mosi = 0; e.rdy = 1;
    e.rv = 0; e.re = 0; e.fc = 0; e.mode = mode_exp; e.rd = 0;
    return e;
  endfunction

  always @(negedge clk) if (rst_n && !finished) begin : cmp
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else e = idle_entry();
    chk("R2", "cs_n", cs_n, e.cs_n);
    chk("R8", "sclk", sclk, e.sclk);
    chk("R3", "mosi", mosi, e.mosi);
    chk("R5", "mode", mode, e.mode);
    chk("R9", "ready", req_ready, e.rdy);
    chk("R9", "rsp_valid", rsp_valid, e.rv);
    chk("R7", "fault_clr", fault_clr, e.fc);
    if (e.rv) begin
      chk("R1/R6", "rsp_err", rsp_err, e.re);
      chk("R4", "rsp_data", rsp_data, e.rd);
    end
  end

  task automatic frame_at(int k, int s, bit [7:0] b, ref exp_t e);
    int h;
    if (k >= s && k < s + FRAME) begin
      h = (k - s) / HALF;
      e.cs_n = 0;
      e.sclk = h[0];
      e.mosi = (h < 16) ? b[7 - h/2] : 1'b0;
    end
  endtask

  task automatic do_access(bit wr, bit [7:0] addr, bit [7:0] data, bit [7:0] slv, bit b2b);
    int kend;
    int s1, d1, s2, d2;
    bit [7:0] b2;
    if (!b2b) @(negedge clk);
    #1;
    req_valid = 1; req_write = wr; req_addr = addr; req_data = data;
    sl_byte = slv;
    if (wr && data[7]) begin
      exp_t e;
      e = idle_entry();
      e.rv = 1; e.re = 1; e.rd = 0;
      q.push_back(e);
      kend = 1;
    end else begin
      s1 = 1 + HALF;
      d1 = s1 + FRAME;
      s2 = d1 + SPI_DIV;
      d2 = s2 + FRAME;
      b2 = wr ? data : 8'h92;
      for (int k = 1; k <= d2; k++) begin
        exp_t e;
        e = idle_entry();
        e.mode = 2'b11;
        e.rdy = (k == d2);
        frame_at(k, s1, addr, e);
        frame_at(k, s2, b2, e);
        if (k == d2) begin
          e.rv = 1;
          if (wr) begin
            e.rd = 0; e.re = 0; e.fc = (addr == 8'hF0);
          end else begin
            e.rd = slv;
            e.re = (addr > 8'h83) && (addr != 8'hFF) && slv[7];
            e.fc = (addr == 8'hFF);
          end
        end
        q.push_back(e);
      end
      mode_exp = 2'b11;
      kend = d2;
    end
    @(negedge clk);
    #1 req_valid = 0;
    repeat (kend - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_data = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "cs_n", cs_n, 1);
    chk("R10", "sclk", sclk, 0);
    chk("R10", "mosi", mosi, 0);
    chk("R10", "ready", req_ready, 1);
    chk("R10", "rsp_valid", rsp_valid, 0);
    chk("R10", "fault_clr", fault_clr, 0);
    chk("R10", "mode", mode, 0);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 refused write before any access: mode stays 00, no strobe
    do_access(1, 8'hF0, 8'h80, 8'h00, 0);
    repeat (3) @(negedge clk);
    // R3 plain write
    do_access(1, 8'h91, 8'h55, 8'h3C, 0);
    // R7 soft-reset write, back to back
    do_access(1, 8'hF0, 8'h00, 8'h00, 1);
    // R1 refused write after mode set
    do_access(1, 8'h88, 8'hFF, 8'h00, 0);
    // R6 parity error on checked register
    do_access(0, 8'h88, 8'h00, 8'hC3, 0);
    // R7 fault register read: bit 7 is not parity
    do_access(0, 8'hFF, 8'h00, 8'hA5, 1);
    // R6 boundary: velocity low byte itself is not checked
    do_access(0, 8'h83, 8'h00, 8'h9C, 0);
    // R4 clean read just above boundary
    do_access(0, 8'h84, 8'h00, 8'h7E, 0);
    // R6 error just above boundary
    do_access(0, 8'h84, 8'h00, 8'h80, 0);
    // R4 read ignores data bit 7
    do_access(0, 8'h92, 8'h80, 8'h4B, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule